// File: doc/BRIEF.md
# Noisy Ripple-Carry Adder Emulator

This block is a ripple-carry adder whose low-order full-adder stages behave like circuits run at a reduced supply. A run-time count selects how many of the least-significant stages are noisy. Each noisy stage can invert its sum output, its carry output, or both, in any cycle. The chance of an inversion is set by a 3-bit supply code. Stages above the selected count always compute exactly. The block lets an arithmetic datapath, such as a transform engine at 16 or 32 bits, be run with controlled, repeatable arithmetic errors, so that output quality can be weighed against the energy a lower supply would save.

Every noisy stage has two private pseudo-random lanes, one for the sum and one for the carry. Each lane is a 16-bit maximal-length LFSR that moves 16 steps per clock, so it presents a fresh 16-bit draw every cycle. A stage inverts an output when that output's draw is below a threshold looked up from the supply code. An inverted carry is the carry that enters the next stage, so a fault ripples upward exactly as a real one would. The seed of every lane is derived from one parameter, so a run can be reproduced. Operands are registered with the result: a result appears on the outputs one clock after its inputs were applied.

Top module: `noisy_ripple_adder`

## Requirements
- R1: While reset is held, the sum, carry-out and fault outputs are all zero.
- R2: The outputs change one clock after the inputs they belong to. With the enable low, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` and `fault_o` is 0.
- R3: With the enable high and a noisy-stage count of 0, the result is the exact sum and `fault_o` is 0.
- R4: Supply codes 0 to 5 stand for 0.8 V to 1.3 V in 0.1 V steps. Code 5 (1.3 V), and codes 6 and 7, never inject a fault, whatever the count.
- R5: Only stages 0 to k-1 can flip, where k is the noisy-stage count; a count above WIDTH acts as WIDTH. With both operands and the carry-in at zero, the result never reaches 2^(k+1). A carry flip in stage k-1 can still set bit k.
- R6: The sum and carry of a noisy stage flip independently. With k = 1 and zero operands, bit 0 of the result shows a sum flip and bit 1 shows a carry flip. Both kinds occur, and so do cycles with both at once.
- R7: The flip threshold out of 65536 is 1514, 832, 426, 184, 85 and 0 for codes 0 to 5. Over 20000 cycles the measured per-output flip count stays within tolerance of that rate: ±25% at code 0 and ±35% at code 2.
- R8: A higher supply code never gives a higher flip rate. The measured counts fall from code 0 to code 2 to code 4.
- R9: `fault_o` is 1 exactly when at least one sum or carry output was inverted for that operation. Any result that differs from the exact sum therefore carries the flag.
- R10: A flipped carry ripples through the exact stages above it. With k = 1 and a = 0xFFFE, b = 0 and cin = 0, the only results are 0x0FFFE, 0x0FFFF, 0x10000 and 0x10001, and 0x10000 does occur.
- R11: The width is a parameter. At a width of 32 the exact sum, including the carry-out, and the R5 bound both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables fault injection; when low the adder is exact |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into stage 0 |
| nbits_i | input | $clog2(WIDTH+1) | Number of noisy low-order stages (k) |
| vcode_i | input | 3 | Supply code, 0 = 0.8 V up to 5 = 1.3 V; 6 and 7 are error-free |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| fault_o | output | 1 | At least one output was inverted in this operation |

## Verification
The bench counts flips at stage 0 with zero operands. A design that shared one noise source between sum and carry would never show both flips in the same cycle. A design with a swapped threshold entry would miss the rate windows or break the falling order across codes. It drives operands that make a flipped carry ripple across fifteen exact stages, which catches a design that drops the carry flip or applies it only to the carry-out. It also bounds the result with k = 4 and at width 32; a mask that lets a stage at or above k flip would break that bound. Exact runs with the enable low, with k = 0 and with supply codes 5 to 7 expose a design that still injects when it should not.

// File: rtl/nra_pkg.sv
package nra_pkg;

    localparam int DRAW_W = 16;
    localparam logic [DRAW_W-1:0] LFSR_TAPS = 16'hB400;

    // Flip threshold out of 65536 for each supply code (0.8 V .. 1.3 V).
    function automatic logic [DRAW_W-1:0] flip_threshold(input logic [2:0] code);
        logic [DRAW_W-1:0] t;
        unique case (code)
            3'd0:    t = 16'd1514;
            3'd1:    t = 16'd832;
            3'd2:    t = 16'd426;
            3'd3:    t = 16'd184;
            3'd4:    t = 16'd85;
            default: t = 16'd0;
        endcase
        return t;
    endfunction

    // Distinct, nonzero starting state for each lane.
    function automatic logic [DRAW_W-1:0] lane_seed(input logic [DRAW_W-1:0] base, input int lane);
        logic [31:0] mix;
        logic [DRAW_W-1:0] s;
        mix = 32'(lane) * 32'h0000_9E37;
        s   = base ^ mix[DRAW_W-1:0];
        if (s == '0) s = 16'hACE1;
        return s;
    endfunction

endpackage

// File: rtl/nra_noise_bank.sv
module nra_noise_bank
    import nra_pkg::*;
#(
    parameter int              LANES     = 32,
    parameter logic [15:0]     SEED_BASE = 16'h1D2B
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [LANES*DRAW_W-1:0]   draws_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DRAW_W-1:0] state_q;
        logic [DRAW_W-1:0] state_n;

        // Advance DRAW_W Galois steps so each draw is a fresh word.
        always_comb begin
            state_n = state_q;
            for (int s = 0; s < DRAW_W; s++) begin
                state_n = state_n[0] ? ((state_n >> 1) ^ LFSR_TAPS) : (state_n >> 1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= lane_seed(SEED_BASE, l);
            else        state_q <= state_n;
        end

        assign draws_o[l*DRAW_W +: DRAW_W] = state_q;

        // R7: a stuck-at-zero lane would silence its stage for good
        a_r7_lane_live: assert property (@(posedge clk) disable iff (!rst_n)
            state_q != '0);
    end

endmodule

// File: rtl/nra_chain.sv
module nra_chain
    import nra_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int KW    = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0]          a_i,
    input  logic [WIDTH-1:0]          b_i,
    input  logic                      cin_i,
    input  logic [KW-1:0]             k_i,
    input  logic [DRAW_W-1:0]         thr_i,
    input  logic [2*WIDTH*DRAW_W-1:0] draws_i,
    output logic [WIDTH-1:0]          sum_o,
    output logic                      cout_o,
    output logic                      fault_o
);

    logic [WIDTH-1:0] flip_s;
    logic [WIDTH-1:0] flip_c;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        logic live;
        assign live      = (KW + 1)'(g) < {1'b0, k_i};
        assign flip_s[g] = live && (draws_i[(2*g)*DRAW_W   +: DRAW_W] < thr_i);
        assign flip_c[g] = live && (draws_i[(2*g+1)*DRAW_W +: DRAW_W] < thr_i);
    end

    // Ripple: an inverted carry is what the next stage receives.
    always_comb begin
        logic carry;
        carry = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            sum_o[i] = a_i[i] ^ b_i[i] ^ carry ^ flip_s[i];
            carry    = ((a_i[i] & b_i[i]) | (a_i[i] & carry) | (b_i[i] & carry)) ^ flip_c[i];
        end
        cout_o = carry;
    end

    assign fault_o = |{flip_s, flip_c};

endmodule

// File: rtl/noisy_ripple_adder.sv
module noisy_ripple_adder
    import nra_pkg::*;
#(
    parameter int          WIDTH     = 16,
    parameter logic [15:0] SEED_BASE = 16'h1D2B,
    parameter int          KW        = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic [KW-1:0]    nbits_i,
    input  logic [2:0]       vcode_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             fault_o
);

    localparam int LANES = 2 * WIDTH;

    logic [KW-1:0]             k_eff;
    logic [DRAW_W-1:0]         thr;
    logic [LANES*DRAW_W-1:0]   draws;
    logic [WIDTH-1:0]          sum_n;
    logic                      cout_n;
    logic                      fault_n;

    always_comb begin
        if (!en_i)                          k_eff = '0;
        else if (nbits_i > KW'(WIDTH))      k_eff = KW'(WIDTH);
        else                                k_eff = nbits_i;
    end

    assign thr = flip_threshold(vcode_i);

    nra_noise_bank #(
        .LANES     (LANES),
        .SEED_BASE (SEED_BASE)
    ) u_noise (
        .clk     (clk),
        .rst_n   (rst_n),
        .draws_o (draws)
    );

    nra_chain #(
        .WIDTH (WIDTH),
        .KW    (KW)
    ) u_chain (
        .a_i     (a_i),
        .b_i     (b_i),
        .cin_i   (cin_i),
        .k_i     (k_eff),
        .thr_i   (thr),
        .draws_i (draws),
        .sum_o   (sum_n),
        .cout_o  (cout_n),
        .fault_o (fault_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o   <= '0;
            cout_o  <= 1'b0;
            fault_o <= 1'b0;
        end else begin
            sum_o   <= sum_n;
            cout_o  <= cout_n;
            fault_o <= fault_n;
        end
    end

    // R2: disabled operations are never flagged
    a_r2_disabled_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !fault_o);

    // R3: zero noisy stages means no fault
    a_r3_zero_bits_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (nbits_i == '0) |=> !fault_o);

    // R4: 1.3 V and the spare codes are error-free
    a_r4_high_supply_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode_i >= 3'd5) |=> !fault_o);

    // R9: an unflagged result is the exact sum of the previous inputs
    a_r9_clean_is_exact: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fault_o || ({cout_o, sum_o} ==
            ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{WIDTH{1'b0}}, $past(cin_i)}))));

endmodule

// File: tb/noisy_ripple_adder_bench.sv
module noisy_ripple_adder_bench;

    localparam int W   = 16;
    localparam int KW  = 5;
    localparam int W2  = 32;
    localparam int KW2 = 6;
    localparam int N   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic          cin = 1'b0;
    logic [KW-1:0] nbits = '0;
    logic [2:0]    vcode = 3'd0;
    logic [W-1:0]  sum;
    logic          cout, fault;

    logic           en2 = 1'b0;
    logic [W2-1:0]  a2 = '0, b2 = '0;
    logic           cin2 = 1'b0;
    logic [KW2-1:0] nbits2 = '0;
    logic [2:0]     vcode2 = 3'd0;
    logic [W2-1:0]  sum2;
    logic           cout2, fault2;

    int checks = 0;
    int errors = 0;
    logic [W:0] exp_q[$];
    string      tag_q[$];
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    noisy_ripple_adder #(.WIDTH(W), .SEED_BASE(16'h1D2B)) u_noisy_ripple_adder (
        .clk(clk), .rst_n(rst_n), .en_i(en), .a_i(a), .b_i(b), .cin_i(cin),
        .nbits_i(nbits), .vcode_i(vcode), .sum_o(sum), .cout_o(cout), .fault_o(fault));

    noisy_ripple_adder #(.WIDTH(W2), .SEED_BASE(16'h5A17)) u_noisy_ripple_adder_w32 (
        .clk(clk), .rst_n(rst_n), .en_i(en2), .a_i(a2), .b_i(b2), .cin_i(cin2),
        .nbits_i(nbits2), .vcode_i(vcode2), .sum_o(sum2), .cout_o(cout2), .fault_o(fault2));

    task automatic chk(input string req, input bit ok, input string detail);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg;
    endfunction

    // Driver: apply one exact operation and queue its expected result
    task automatic drive_exact(input string req, input logic e, input logic [KW-1:0] k,
                               input logic [2:0] code, input logic [W-1:0] x,
                               input logic [W-1:0] y, input logic c);
        @(negedge clk);
        en = e; nbits = k; vcode = code; a = x; b = y; cin = c;
        exp_q.push_back({1'b0, x} + {1'b0, y} + {{W{1'b0}}, c});
        tag_q.push_back(req);
    endtask

    // Monitor: result is registered at the edge after the drive
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [W:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, ({cout, sum} == e) && !fault,
                $sformatf("result %h fault %b, expected %h fault 0", {cout, sum}, fault, e));
        end
    end

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Zero operands: count flips of stage-0 sum (bit 0) and carry (bit 1)
    task automatic run_zero(input logic [KW-1:0] k, input logic [2:0] code, input int n,
                            output int cs, output int cc, output int cb,
                            output int fmis, output logic [W:0] maxv, output int hi4);
        cs = 0; cc = 0; cb = 0; fmis = 0; maxv = '0; hi4 = 0;
        for (int i = 0; i < n; i++) begin
            logic [W:0] r;
            @(negedge clk);
            en = 1'b1; nbits = k; vcode = code; a = '0; b = '0; cin = 1'b0;
            @(posedge clk);
            #2;
            r = {cout, sum};
            if (r[0]) cs++;
            if (r[1]) cc++;
            if (r[0] && r[1]) cb++;
            if (r[4]) hi4++;
            if (fault != (r != '0)) fmis++;
            if (r > maxv) maxv = r;
        end
    endtask

    initial begin
        int cs0, cc0, cb0, fm0, h0;
        int cs2, cc2, cb2, fm2, h2;
        int cs4, cc4, cb4, fm4, h4;
        logic [W:0] mx;
        real e0, e2;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", sum == '0 && cout == 1'b0 && fault == 1'b0,
            $sformatf("sum %h cout %b fault %b, expected 0 0 0", sum, cout, fault));
        chk("R1", sum2 == '0 && cout2 == 1'b0 && fault2 == 1'b0,
            $sformatf("w32 sum %h cout %b fault %b, expected 0 0 0", sum2, cout2, fault2));
        rst_n = 1'b1;

        // R2: enable low gives exact sums, worst supply, all stages noisy
        drive_exact("R2", 1'b0, KW'(W), 3'd0, 16'hFFFF, 16'h0001, 1'b0);
        drive_exact("R2", 1'b0, KW'(W), 3'd0, 16'hFFFF, 16'hFFFF, 1'b1);
        drive_exact("R2", 1'b0, KW'(W), 3'd0, 16'h0000, 16'h0000, 1'b0);
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            r = next_rand();
            drive_exact("R2", 1'b0, KW'(W), 3'd0, r[15:0], r[31:16], r[3]);
        end
        // R3: zero noisy stages
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            r = next_rand();
            drive_exact("R3", 1'b1, '0, 3'd0, r[31:16], r[15:0], r[7]);
        end
        // R4: supply codes 5, 6 and 7 never inject
        for (int c = 5; c < 8; c++) begin
            for (int i = 0; i < 400; i++) begin
                logic [31:0] r;
                r = next_rand();
                drive_exact("R4", 1'b1, KW'(31), 3'(c), r[15:0], r[31:16], r[11]);
            end
        end
        drain();

        // R6, R7, R9: stage-0 flips at code 0, then code 2 and code 4 for R8
        run_zero(KW'(1), 3'd0, N, cs0, cc0, cb0, fm0, mx, h0);
        chk("R5", mx < 17'd4, $sformatf("max result %h, expected below 4", mx));
        chk("R9", fm0 == 0, $sformatf("%0d flag mismatches, expected 0", fm0));
        chk("R6", cb0 > 0, $sformatf("%0d joint flips, expected at least 1", cb0));
        e0 = real'(N) * 1513.0 / 65535.0;
        chk("R7", real'(cs0) > 0.75 * e0 && real'(cs0) < 1.25 * e0,
            $sformatf("code0 sum flips %0d, expected about %0.1f", cs0, e0));
        chk("R7", real'(cc0) > 0.75 * e0 && real'(cc0) < 1.25 * e0,
            $sformatf("code0 carry flips %0d, expected about %0.1f", cc0, e0));

        run_zero(KW'(1), 3'd2, N, cs2, cc2, cb2, fm2, mx, h2);
        e2 = real'(N) * 425.0 / 65535.0;
        chk("R7", real'(cs2) > 0.65 * e2 && real'(cs2) < 1.35 * e2,
            $sformatf("code2 sum flips %0d, expected about %0.1f", cs2, e2));
        chk("R7", real'(cc2) > 0.65 * e2 && real'(cc2) < 1.35 * e2,
            $sformatf("code2 carry flips %0d, expected about %0.1f", cc2, e2));
        chk("R9", fm2 == 0, $sformatf("%0d flag mismatches, expected 0", fm2));

        run_zero(KW'(1), 3'd4, N, cs4, cc4, cb4, fm4, mx, h4);
        chk("R8", (cs0 + cc0) > (cs2 + cc2) && (cs2 + cc2) > (cs4 + cc4),
            $sformatf("flip totals %0d/%0d/%0d, expected strictly falling",
                      cs0 + cc0, cs2 + cc2, cs4 + cc4));

        // R5: k = 4 bounds the result below 32, and bit 4 is reachable
        run_zero(KW'(4), 3'd0, 4000, cs4, cc4, cb4, fm4, mx, h4);
        chk("R5", mx < 17'd32, $sformatf("max result %h, expected below 20", mx));
        chk("R5", h4 > 0, $sformatf("bit4 seen %0d times, expected more than 0", h4));

        // R10: carry flip ripples across the exact upper stages
        begin
            int bad = 0;
            int wrap = 0;
            for (int i = 0; i < 4000; i++) begin
                logic [W:0] r;
                @(negedge clk);
                en = 1'b1; nbits = KW'(1); vcode = 3'd0; a = 16'hFFFE; b = '0; cin = 1'b0;
                @(posedge clk);
                #2;
                r = {cout, sum};
                if (r == 17'h10000) wrap++;
                else if (r != 17'h0FFFE && r != 17'h0FFFF && r != 17'h10001) bad++;
            end
            chk("R10", bad == 0, $sformatf("%0d results outside the set, expected 0", bad));
            chk("R10", wrap > 0, $sformatf("wrap to 10000 seen %0d times, expected more than 0", wrap));
        end

        // R11: 32-bit width, exact and bounded
        @(negedge clk);
        en2 = 1'b0; nbits2 = KW2'(W2); vcode2 = 3'd0;
        a2 = 32'hFFFF_FFFF; b2 = 32'h0000_0001; cin2 = 1'b1;
        @(posedge clk);
        #2;
        chk("R11", {cout2, sum2} == 33'h1_0000_0001 && !fault2,
            $sformatf("w32 result %h fault %b, expected 100000001 fault 0", {cout2, sum2}, fault2));
        begin
            logic [W2:0] m2 = '0;
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk);
                en2 = 1'b1; nbits2 = KW2'(8); vcode2 = 3'd0; a2 = '0; b2 = '0; cin2 = 1'b0;
                @(posedge clk);
                #2;
                if ({cout2, sum2} > m2) m2 = {cout2, sum2};
            end
            chk("R11", m2 < 33'd512, $sformatf("w32 max %h, expected below 200", m2));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(190000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule